// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between a CPU and its memories. For each byte access on a 24-bit address it names one target region and gives the byte offset inside that region. It drives a write enable only when the target can be written. It raises a flag when an unmapped or blank location is read, so the read returns 0xFF. It raises a second flag when the access belongs to the display controller instead of memory. The memory arrays, the ROM contents and the display controller sit outside the block.

Four I/O-programmable registers control the map:
- a 6-bit window that moves a 256 KB slice of physical space into CPU addresses 0x080000–0x0BFFFF;
- a video bank register that selects one of four 128 KB video planes, or routes the video range to the display controller;
- a dictionary page register;
- a character-ROM page register.

A read and a write to the same address can reach different targets. This is how the boot ROM shadows the PCG and text RAM until software switches the map.

The upper boot area at 0x0F0000–0x0F7FFF follows a small state machine with three states:
- `MS_RESET`: the boot ROM is shadowed across the whole area.
- `MS_LOWLIVE`: 0x0F0000–0x0F0FFF is live.
- `MS_FULL`: the whole area is live.

The machine has three named transitions:
- `T_CHR_ARM`, from `MS_RESET` to `MS_LOWLIVE`, on a write to the character register.
- `T_VID_CLEAR`, from `MS_RESET` or `MS_LOWLIVE` to `MS_FULL`, on a write of 0 to the video register.
- `T_HOLD`, which keeps `MS_FULL` in place.

A second access port, used for DMA, takes precedence over the CPU port whenever one of its strobes is high. It skips both the window and the display redirection.

Top module: `bank_map_decoder`

## Requirements
- R1: After reset, physical addresses decode as follows:

  | Range | Region | Code | Access | Offset |
  |---|---|---|---|---|
  | 0x000000–0x0BFFFF | main RAM | 1 | read/write | the address |
  | 0x0C0000–0x0DFFFF | video RAM | 2 | read/write | plane×0x20000 + (address−0x0C0000) |
  | 0x0E0000–0x0EFFFF | dictionary | 3 | read only | page×0x10000 + (address−0x0E0000) |
  | 0x200000–0x7FFFFF | extension RAM | 4 | read/write | address−0x200000 |
  | 0xFF0000–0xFFFFFF | boot ROM | 5 | read only | address AND 0xFFFF |

  All other space outside 0x0F0000–0x0FFFFF is region 0, meaning none.
- R2: In state `MS_RESET`, reads of 0x0F0000–0x0FFFFF reach boot ROM (region 5) at offset address−0x0F0000. Writes there go as follows:
  - 0x0F0000–0x0F3FFF: PCG (region 6), offset address−0x0F0000.
  - 0x0F4000–0x0F7FFF: text RAM (region 7), offset (address−0x0F4000) mod 0x2000, so both 8 KB halves hit the same cells.
  - 0x0F8000–0x0FFFFF: discarded.
- R3: A read of region 0 raises the blank-read flag with the read enable low. A write to a read-only or unmapped target leaves the write enable low, and its offset is 0.
- R4: A CPU access whose bits [23:18] equal 2 is decoded at physical address {window, address[17:0]}. The window resets to 2 and is I/O port 0x8C, bits [5:0].
- R5: When the video register is 0, a CPU access to 0x0C0000–0x0DFFFF raises the display flag. In that case the region is 0, the write and read enables are low, and the offset is address−0x0C0000.
- R6: Writing 4 to 7 to I/O 0x8D selects video plane value−4. Any other value leaves the plane unchanged. The plane is 0 after reset.
- R7: Writing 0 to I/O 0x8D enters `MS_FULL`, which lasts until reset:
  - 0x0F1000–0x0F3FFF reads and writes PCG at address−0x0F0000.
  - 0x0F4000–0x0F7FFF reads and writes text RAM.
  - 0x0F0000–0x0F0FFF follows the character register.
- R8: Bits [4:3] of I/O 0xCE select the dictionary page. The other bits do not affect decoding.
- R9: Any write to I/O 0x274 makes 0x0F0000–0x0F0FFF live.
  - With bit 7 set, reads there reach the character ROM (region 8) at offset page×0x1000 + (address−0x0F0000), where the page is data[6:0]. Writes there are discarded.
  - With bit 7 clear, the range reads and writes PCG.
- R10: A read of an odd character-ROM offset raises the blank-read flag with the read enable low.
- R11: I/O decoding uses address bits [14:0]. Ports 0x8C, 0x8D, 0xCE and 0x274 read back their stored values (the window zero-extended), and every other port reads 0xFF.
- R12: When a DMA strobe is high, the DMA port's address is decoded directly, with no window and no display redirection.
- R13: A register write takes effect on the clock edge that samples the I/O write strobe. An access in that same cycle still decodes with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 24 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| dma_addr | input | 24 | DMA byte address (physical) |
| dma_rd | input | 1 | DMA read strobe |
| dma_wr | input | 1 | DMA write strobe |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for io_addr |
| acc_tgt | output | 4 | Region code (R1, R2, R9) |
| acc_off | output | 24 | Offset inside the region |
| acc_we | output | 1 | Write enable to the region |
| acc_re | output | 1 | Read enable from the region |
| acc_blank | output | 1 | Read returns 0xFF |
| acc_disp | output | 1 | Access routed to the display controller |

## Verification
Each pattern targets a distinction the decoder must get right:

| Pattern | What it separates |
|---|---|
| A read and a write to the same shadowed address in every map state | The read map from the write map, and each state from the others |
| The same address issued on the CPU port and on the DMA port | Window and display redirection from direct decoding |
| Window values that land in main RAM, video RAM, extension RAM and unmapped space | Wrong concatenation of the window with the low address bits |
| Register writes with neighbouring values, and an access in the same cycle as the write | Masking (plane values outside 4–7, dictionary bits outside [4:3], port bit 15) and the timing of the update |

// File: rtl/bmd_pkg.sv
package bmd_pkg;
    localparam int ADDR_W = 24;
    localparam int IO_AW  = 15;
    localparam int WIN_W  = 6;

    typedef enum logic [3:0] {
        RG_NONE = 4'd0,
        RG_MAIN = 4'd1,
        RG_VRAM = 4'd2,
        RG_DICT = 4'd3,
        RG_EXT  = 4'd4,
        RG_BOOT = 4'd5,
        RG_PCG  = 4'd6,
        RG_TEXT = 4'd7,
        RG_CHAR = 4'd8
    } region_e;

    typedef enum logic [1:0] {
        MS_RESET   = 2'd0,
        MS_LOWLIVE = 2'd1,
        MS_FULL    = 2'd2
    } map_state_e;
endpackage

// File: rtl/bmd_regs.sv
module bmd_regs
    import bmd_pkg::*;
#(
    parameter logic [IO_AW-1:0] WIN_PORT = 15'h008C,
    parameter logic [IO_AW-1:0] VID_PORT = 15'h008D,
    parameter logic [IO_AW-1:0] DIC_PORT = 15'h00CE,
    parameter logic [IO_AW-1:0] CHR_PORT = 15'h0274,
    parameter logic [WIN_W-1:0] WIN_RST  = 6'd2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      io_addr,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic [WIN_W-1:0] win,
    output logic             vid_zero,
    output logic [1:0]       plane,
    output logic [1:0]       dic_page,
    output logic             chr_rom,
    output logic [6:0]       chr_page,
    output map_state_e       map_state
);
    logic [IO_AW-1:0] port;
    logic wr_win, wr_vid, wr_dic, wr_chr;
    logic [WIN_W-1:0] win_q;
    logic [7:0] vid_q, dic_q, chr_q;
    logic [1:0] plane_q;
    map_state_e st_q, st_nx;

    assign port   = io_addr[IO_AW-1:0];
    assign wr_win = io_wr && (port == WIN_PORT);
    assign wr_vid = io_wr && (port == VID_PORT);
    assign wr_dic = io_wr && (port == DIC_PORT);
    assign wr_chr = io_wr && (port == CHR_PORT);

    // register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= WIN_RST;
            vid_q   <= 8'h00;
            dic_q   <= 8'h00;
            chr_q   <= 8'h00;
            plane_q <= 2'd0;
        end else begin
            if (wr_win) win_q <= io_wdata[WIN_W-1:0];
            if (wr_vid) begin
                vid_q <= io_wdata;
                if (io_wdata[7:2] == 6'd1) plane_q <= io_wdata[1:0];
            end
            if (wr_dic) dic_q <= io_wdata;
            if (wr_chr) chr_q <= io_wdata;
        end
    end

    // map state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MS_RESET;
        else        st_q <= st_nx;
    end

    // map state transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            MS_RESET: begin
                if (wr_vid && io_wdata == 8'h00) st_nx = MS_FULL;      // T_VID_CLEAR
                else if (wr_chr)                 st_nx = MS_LOWLIVE;   // T_CHR_ARM
            end
            MS_LOWLIVE: begin
                if (wr_vid && io_wdata == 8'h00) st_nx = MS_FULL;      // T_VID_CLEAR
            end
            MS_FULL: st_nx = MS_FULL;                                  // T_HOLD
            default: st_nx = MS_RESET;
        endcase
    end

    // read-back
    always_comb begin
        if      (port == WIN_PORT) io_rdata = {{(8-WIN_W){1'b0}}, win_q};
        else if (port == VID_PORT) io_rdata = vid_q;
        else if (port == DIC_PORT) io_rdata = dic_q;
        else if (port == CHR_PORT) io_rdata = chr_q;
        else                       io_rdata = 8'hFF;
    end

    assign win       = win_q;
    assign vid_zero  = (vid_q == 8'h00);
    assign plane     = plane_q;
    assign dic_page  = dic_q[4:3];
    assign chr_rom   = chr_q[7];
    assign chr_page  = chr_q[6:0];
    assign map_state = st_q;

    assert_win_update_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win |=> win_q == $past(io_wdata[WIN_W-1:0]));
    assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == MS_FULL |=> st_q == MS_FULL);
    assert_plane_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vid && io_wdata[7:2] != 6'd1) |=> $stable(plane_q));
    assert_rdata_default_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (port != WIN_PORT && port != VID_PORT && port != DIC_PORT && port != CHR_PORT)
        |-> io_rdata == 8'hFF);
endmodule

// File: rtl/bmd_xlate.sv
module bmd_xlate
    import bmd_pkg::*;
(
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_rd,
    input  logic              dma_wr,
    input  logic [WIN_W-1:0]  win,
    input  logic              vid_zero,
    output logic [ADDR_W-1:0] phys,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic              disp_hit
);
    localparam int LOW_W = ADDR_W - WIN_W;
    localparam logic [WIN_W-1:0] WIN_SLOT = 6'd2;   // 0x080000 >> 18
    localparam logic [6:0]       VID_SLOT = 7'd6;   // 0x0C0000 >> 17

    logic dma_act, in_win, in_vid;

    assign dma_act = dma_rd | dma_wr;
    assign in_win  = cpu_addr[ADDR_W-1:LOW_W] == WIN_SLOT;
    assign in_vid  = cpu_addr[ADDR_W-1:17] == VID_SLOT;

    always_comb begin
        if (dma_act) begin
            phys     = dma_addr;
            acc_rd   = dma_rd;
            acc_wr   = dma_wr;
            disp_hit = 1'b0;
        end else begin
            phys     = in_win ? {win, cpu_addr[LOW_W-1:0]} : cpu_addr;
            acc_rd   = cpu_rd;
            acc_wr   = cpu_wr;
            disp_hit = in_vid && vid_zero && (cpu_rd || cpu_wr);
        end
    end
endmodule

// File: rtl/bmd_region.sv
module bmd_region
    import bmd_pkg::*;
(
    input  logic [ADDR_W-1:0] phys,
    input  logic [1:0]        plane,
    input  logic [1:0]        dic_page,
    input  logic              chr_rom,
    input  logic [6:0]        chr_page,
    input  map_state_e        map_state,
    output region_e           rd_tgt,
    output logic [ADDR_W-1:0] rd_off,
    output region_e           wr_tgt,
    output logic [ADDR_W-1:0] wr_off
);
    logic lo_live, hi_live;
    logic [ADDR_W-1:0] boot_off, pcg_off, text_off;

    assign lo_live  = (map_state != MS_RESET);
    assign hi_live  = (map_state == MS_FULL);
    assign boot_off = {8'h00, phys[15:0]};
    assign pcg_off  = {10'd0, phys[13:0]};
    assign text_off = {11'd0, phys[12:0]};

    always_comb begin
        rd_tgt = RG_NONE;  rd_off = '0;
        wr_tgt = RG_NONE;  wr_off = '0;
        if (phys[23:18] < 6'd3) begin
            rd_tgt = RG_MAIN; rd_off = phys;
            wr_tgt = RG_MAIN; wr_off = phys;
        end else if (phys[23:17] == 7'd6) begin
            rd_tgt = RG_VRAM; rd_off = {5'd0, plane, phys[16:0]};
            wr_tgt = RG_VRAM; wr_off = {5'd0, plane, phys[16:0]};
        end else if (phys[23:16] == 8'h0E) begin
            rd_tgt = RG_DICT; rd_off = {6'd0, dic_page, phys[15:0]};
        end else if (phys[23:16] == 8'h0F) begin
            if (phys[15]) begin
                rd_tgt = RG_BOOT; rd_off = boot_off;
            end else if (phys[14]) begin
                wr_tgt = RG_TEXT; wr_off = text_off;
                if (hi_live) begin
                    rd_tgt = RG_TEXT; rd_off = text_off;
                end else begin
                    rd_tgt = RG_BOOT; rd_off = boot_off;
                end
            end else if (phys[13:12] == 2'b00) begin
                if (lo_live && chr_rom) begin
                    rd_tgt = RG_CHAR; rd_off = {5'd0, chr_page, phys[11:0]};
                end else begin
                    wr_tgt = RG_PCG; wr_off = pcg_off;
                    if (lo_live) begin
                        rd_tgt = RG_PCG;  rd_off = pcg_off;
                    end else begin
                        rd_tgt = RG_BOOT; rd_off = boot_off;
                    end
                end
            end else begin
                wr_tgt = RG_PCG; wr_off = pcg_off;
                if (hi_live) begin
                    rd_tgt = RG_PCG;  rd_off = pcg_off;
                end else begin
                    rd_tgt = RG_BOOT; rd_off = boot_off;
                end
            end
        end else if (phys[23:21] != 3'd0 && phys[23] == 1'b0) begin
            rd_tgt = RG_EXT; rd_off = phys - 24'h200000;
            wr_tgt = RG_EXT; wr_off = phys - 24'h200000;
        end else if (phys[23:16] == 8'hFF) begin
            rd_tgt = RG_BOOT; rd_off = boot_off;
        end
    end
endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
    import bmd_pkg::*;
#(
    parameter logic [IO_AW-1:0] WIN_PORT = 15'h008C,
    parameter logic [IO_AW-1:0] VID_PORT = 15'h008D,
    parameter logic [IO_AW-1:0] DIC_PORT = 15'h00CE,
    parameter logic [IO_AW-1:0] CHR_PORT = 15'h0274,
    parameter logic [WIN_W-1:0] WIN_RST  = 6'd2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [23:0] dma_addr,
    input  logic        dma_rd,
    input  logic        dma_wr,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic [3:0]  acc_tgt,
    output logic [23:0] acc_off,
    output logic        acc_we,
    output logic        acc_re,
    output logic        acc_blank,
    output logic        acc_disp
);
    logic [WIN_W-1:0] win;
    logic vid_zero, chr_rom;
    logic [1:0] plane, dic_page;
    logic [6:0] chr_page;
    map_state_e map_state;
    logic [ADDR_W-1:0] phys, rd_off, wr_off;
    logic a_rd, a_wr, disp_hit, odd_chr;
    region_e rd_tgt, wr_tgt, sel_tgt;

    bmd_regs #(
        .WIN_PORT(WIN_PORT), .VID_PORT(VID_PORT), .DIC_PORT(DIC_PORT),
        .CHR_PORT(CHR_PORT), .WIN_RST(WIN_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .win(win), .vid_zero(vid_zero),
        .plane(plane), .dic_page(dic_page), .chr_rom(chr_rom), .chr_page(chr_page),
        .map_state(map_state)
    );

    bmd_xlate u_xlate (
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .dma_addr(dma_addr), .dma_rd(dma_rd), .dma_wr(dma_wr),
        .win(win), .vid_zero(vid_zero),
        .phys(phys), .acc_rd(a_rd), .acc_wr(a_wr), .disp_hit(disp_hit)
    );

    bmd_region u_region (
        .phys(phys), .plane(plane), .dic_page(dic_page), .chr_rom(chr_rom),
        .chr_page(chr_page), .map_state(map_state),
        .rd_tgt(rd_tgt), .rd_off(rd_off), .wr_tgt(wr_tgt), .wr_off(wr_off)
    );

    assign odd_chr = (rd_tgt == RG_CHAR) && rd_off[0];
    assign sel_tgt = disp_hit ? RG_NONE : (a_wr ? wr_tgt : rd_tgt);

    always_comb begin
        acc_tgt   = sel_tgt;
        acc_off   = disp_hit ? {7'd0, cpu_addr[16:0]} : (a_wr ? wr_off : rd_off);
        acc_we    = a_wr && !disp_hit && (wr_tgt != RG_NONE);
        acc_re    = a_rd && !a_wr && !disp_hit && (rd_tgt != RG_NONE) && !odd_chr;
        acc_blank = a_rd && !a_wr && !disp_hit && ((rd_tgt == RG_NONE) || odd_chr);
        acc_disp  = disp_hit;
    end

    assert_we_writable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> (acc_tgt == RG_MAIN || acc_tgt == RG_VRAM || acc_tgt == RG_EXT ||
                    acc_tgt == RG_PCG  || acc_tgt == RG_TEXT));
    assert_disp_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_disp |-> (!acc_we && !acc_re && acc_tgt == RG_NONE));
    assert_blank_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_blank |-> !acc_re);
    assert_dma_no_disp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd || dma_wr) |-> !acc_disp);
endmodule

// File: tb/bank_map_decoder_bench.sv
`timescale 1ns/1ps
module bank_map_decoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [23:0] cpu_addr = '0, dma_addr = '0;
    logic cpu_rd = 0, cpu_wr = 0, dma_rd = 0, dma_wr = 0;
    logic [15:0] io_addr = '0;
    logic io_wr = 0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [3:0] acc_tgt;
    logic [23:0] acc_off;
    logic acc_we, acc_re, acc_blank, acc_disp;

    always #2.5 clk = ~clk;

    bank_map_decoder u_bank_map_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .dma_addr(dma_addr), .dma_rd(dma_rd), .dma_wr(dma_wr), .io_addr(io_addr),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .acc_tgt(acc_tgt),
        .acc_off(acc_off), .acc_we(acc_we), .acc_re(acc_re), .acc_blank(acc_blank),
        .acc_disp(acc_disp)
    );

    int n_cmp = 0, n_bad = 0;
    // reference model state
    int m_win = 2, m_vid = 0, m_plane = 0, m_dic = 0, m_chr = 0;
    bit m_lo = 0, m_hi = 0;
    int e_tgt, e_off, e_rdata;
    bit e_we, e_re, e_blank, e_disp;

    task automatic predict(input int a, input bit r, input bit w, input bit dma);
        int p, o, rt, ro, wt, wo;
        p = a; rt = 0; ro = 0; wt = 0; wo = 0;
        if (!dma && a >= 'h80000 && a < 'hC0000) p = (a % 'h40000) + m_win * 'h40000;
        e_disp = !dma && (r || w) && a >= 'hC0000 && a < 'hE0000 && m_vid == 0;
        if (p < 'hC0000) begin rt = 1; ro = p; wt = 1; wo = p; end
        else if (p < 'hE0000) begin rt = 2; ro = m_plane * 'h20000 + p - 'hC0000; wt = 2; wo = ro; end
        else if (p < 'hF0000) begin rt = 3; ro = ((m_dic / 8) % 4) * 'h10000 + p - 'hE0000; end
        else if (p < 'h100000) begin
            o = p - 'hF0000;
            if (o >= 'h8000) begin rt = 5; ro = o; end
            else if (o >= 'h4000) begin
                wt = 7; wo = (o - 'h4000) % 'h2000;
                if (m_hi) begin rt = 7; ro = wo; end else begin rt = 5; ro = o; end
            end else if (o >= 'h1000) begin
                wt = 6; wo = o;
                if (m_hi) begin rt = 6; ro = o; end else begin rt = 5; ro = o; end
            end else if (m_lo && m_chr >= 128) begin
                rt = 8; ro = (m_chr % 128) * 'h1000 + o;
            end else begin
                wt = 6; wo = o;
                if (m_lo) begin rt = 6; ro = o; end else begin rt = 5; ro = o; end
            end
        end
        else if (p >= 'h200000 && p < 'h800000) begin rt = 4; ro = p - 'h200000; wt = 4; wo = ro; end
        else if (p >= 'hFF0000) begin rt = 5; ro = p - 'hFF0000; end
        e_we = 0; e_re = 0; e_blank = 0;
        if (e_disp) begin e_tgt = 0; e_off = a - 'hC0000; end
        else if (w) begin e_tgt = wt; e_off = wo; e_we = (wt != 0); end
        else begin
            e_tgt = rt; e_off = ro;
            e_blank = r && (rt == 0 || (rt == 8 && ro % 2 == 1));
            e_re = r && !e_blank;
        end
    endtask

    function automatic int io_expect(input int pa);
        case (pa % 'h8000)
            'h8C:  return m_win;
            'h8D:  return m_vid;
            'hCE:  return m_dic;
            'h274: return m_chr;
            default: return 'hFF;
        endcase
    endfunction

    task automatic model_io_write(input int pa, input int d);
        case (pa % 'h8000)
            'h8C: m_win = d % 64;
            'h8D: begin
                if (d == 0) begin m_lo = 1; m_hi = 1; end
                if (d >= 4 && d <= 7) m_plane = d - 4;
                m_vid = d;
            end
            'hCE: m_dic = d;
            'h274: begin m_chr = d; m_lo = 1; end
            default: ;
        endcase
    endtask

    task automatic fail_line(input string req, input string what, input int act, input int exp);
        $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    endtask

    // one clock: drive, compare mid-phase, advance model at the edge
    task automatic step(input string req, input int ca, input bit cr, input bit cw,
                        input int da, input bit dr, input bit dw,
                        input int ia, input bit iw, input int id);
        bit bad, dma;
        cpu_addr = ca[23:0]; cpu_rd = cr; cpu_wr = cw;
        dma_addr = da[23:0]; dma_rd = dr; dma_wr = dw;
        io_addr = ia[15:0]; io_wr = iw; io_wdata = id[7:0];
        #1;
        dma = dr || dw;
        predict(dma ? da : ca, dma ? dr : cr, dma ? dw : cw, dma);
        e_rdata = io_expect(ia);
        bad = 0;
        if (int'(acc_tgt) != e_tgt)  begin bad = 1; fail_line(req, "tgt", int'(acc_tgt), e_tgt); end
        if (int'(acc_off) != e_off)  begin bad = 1; fail_line(req, "off", int'(acc_off), e_off); end
        if (acc_we != e_we)          begin bad = 1; fail_line(req, "we", int'(acc_we), int'(e_we)); end
        if (acc_re != e_re)          begin bad = 1; fail_line(req, "re", int'(acc_re), int'(e_re)); end
        if (acc_blank != e_blank)    begin bad = 1; fail_line(req, "blank", int'(acc_blank), int'(e_blank)); end
        if (acc_disp != e_disp)      begin bad = 1; fail_line(req, "disp", int'(acc_disp), int'(e_disp)); end
        if (int'(io_rdata) != e_rdata) begin bad = 1; fail_line(req, "io_rdata", int'(io_rdata), e_rdata); end
        n_cmp++;
        if (bad) n_bad++;
        @(posedge clk);
        if (iw) model_io_write(ia, id);
        @(negedge clk);
    endtask

    task automatic crd(input string q, input int a); step(q, a, 1, 0, 0, 0, 0, 'h8C, 0, 0); endtask
    task automatic cwr(input string q, input int a); step(q, a, 0, 1, 0, 0, 0, 'h8C, 0, 0); endtask
    task automatic drd(input string q, input int a); step(q, 0, 0, 0, a, 1, 0, 'h8D, 0, 0); endtask
    task automatic dwr(input string q, input int a); step(q, 0, 0, 0, a, 0, 1, 'h8D, 0, 0); endtask
    task automatic iow(input string q, input int pa, input int d); step(q, 0, 0, 0, 0, 0, 0, pa, 1, d); endtask
    task automatic ior(input string q, input int pa); step(q, 0, 0, 0, 0, 0, 0, pa, 0, 0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL R13 watchdog: actual=cycle limit reached expected=run complete");
        n_bad++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset values and default read-back, bit 15 ignored
        ior("R11", 'h8C); ior("R11", 'h808C); ior("R11", 'h8D); ior("R11", 'hCE);
        ior("R11", 'h274); ior("R11", 'h123); ior("R11", 'h8E);
        // R1: reset map via DMA and CPU
        crd("R1", 'h000100); cwr("R1", 'h07FFFF); drd("R1", 'h0C0100); dwr("R1", 'h0DFFFF);
        crd("R1", 'h0E1234); cwr("R1", 'h0E0000); crd("R1", 'h300000); cwr("R1", 'h7FFFFF);
        crd("R1", 'hFF8001); cwr("R1", 'hFF0000);
        // R3: unmapped and read-only
        crd("R3", 'h150000); cwr("R3", 'h900000); crd("R3", 'hFEFFFF); crd("R3", 'h1FFFFF);
        // R2: shadowed boot area in reset state
        crd("R2", 'h0F0010); cwr("R2", 'h0F0010); crd("R2", 'h0F2345); cwr("R2", 'h0F3FFF);
        crd("R2", 'h0F4005); cwr("R2", 'h0F4005); cwr("R2", 'h0F6005); crd("R2", 'h0F7FFF);
        crd("R2", 'h0F9000); cwr("R2", 'h0F9000);
        // R4: window
        crd("R4", 'h080123); iow("R4", 'h8C, 8); crd("R4", 'h080123); cwr("R4", 'h0BFFFF);
        iow("R4", 'h8C, 3); crd("R4", 'h081000); iow("R4", 'h8C, 'hFF); crd("R4", 'h080000);
        ior("R4", 'h8C);
        iow("R4", 'h8C, 8);
        // R12: DMA skips window and display
        drd("R12", 'h080123); dwr("R12", 'h0BFFFF); drd("R12", 'h0C8000);
        // R5: display redirect
        crd("R5", 'h0C8000); cwr("R5", 'h0DFFFF); crd("R5", 'h0E0000);
        // R6: video planes
        iow("R6", 'h8D, 6); crd("R6", 'h0C1000); cwr("R6", 'h0DFFFE); ior("R6", 'h8D);
        iow("R6", 'h8D, 9); crd("R6", 'h0C1000); iow("R6", 'h8D, 7); drd("R6", 'h0C0001);
        iow("R6", 'h8D, 4); cwr("R6", 'h0C0002);
        // R8: dictionary pages
        iow("R8", 'hCE, 'h18); crd("R8", 'h0E0001); iow("R8", 'hCE, 'h10); crd("R8", 'h0EFFFF);
        iow("R8", 'hCE, 'hE7); crd("R8", 'h0E4444); ior("R8", 'hCE);
        // R9: character register arms the low 4 KB only
        iow("R9", 'h274, 'h85); crd("R9", 'h0F0010); cwr("R9", 'h0F0010);
        crd("R9", 'h0F1000); crd("R9", 'h0F4000); ior("R9", 'h274);
        // R10: odd character offsets are blank
        crd("R10", 'h0F0011); crd("R10", 'h0F0FFF); drd("R10", 'h0F0FFE);
        iow("R9", 'h274, 'h03); crd("R9", 'h0F0010); cwr("R9", 'h0F0011);
        // R13: access in the same cycle as a register write uses the old value
        step("R13", 'h080010, 1, 0, 0, 0, 0, 'h8C, 1, 'h0A);
        crd("R13", 'h080010);
        step("R13", 'h0E0000, 1, 0, 0, 0, 0, 'hCE, 1, 'h08);
        crd("R13", 'h0E0000);
        // R7: video register 0 fully opens the upper boot area
        iow("R7", 'h274, 'h82);
        step("R7", 'h0F1000, 1, 0, 0, 0, 0, 'h8D, 1, 0);
        crd("R7", 'h0F1000); cwr("R7", 'h0F2000); crd("R7", 'h0F5001); crd("R7", 'h0F7001);
        crd("R7", 'h0F0020); crd("R7", 'h0F8000); crd("R5", 'h0C0000);
        iow("R7", 'h274, 'h00); crd("R7", 'h0F0020); cwr("R7", 'h0F0020);
        iow("R7", 'h8D, 5); crd("R7", 'h0F3000); drd("R6", 'h0C0000);
        for (int i = 0; i < 16; i++) begin
            crd("R1", i * 'h100000 + 'h3F7F1);
            cwr("R1", i * 'h0F0000 + 'h1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule